// File: doc/BRIEF.md
# RC4 Keystream Generator

This block turns a short secret key into a byte-wide RC4 pseudo-random keystream. Surrounding logic XORs the stream with data to encrypt or decrypt it. Once reset is released, the block takes one key byte per clock from its byte input. It stops after a fixed number of key bytes. It then builds the 256-entry permutation from that key.

Before exposing anything, the block runs the generator internally and throws away the first 1536 output bytes. Those early bytes are known to be statistically weak. When the discard ends, a ready flag rises and the current keystream byte becomes valid. The consumer then pulls further bytes one at a time with a request strobe.

The permutation is kept in flip-flops, so every key-scheduling swap and every generator step finishes in a single clock. The five phases are: key capture, permutation initialisation, key scheduling, discard and output.

Top module: `rc4_stream_gen`

## Requirements
- R1: While `rst` is high, `ready` is low after every clock edge. The generator returns to key capture with both indices and the key position at zero.
- R2: After `rst` falls, the block captures `key_byte` on each of the next 7 rising edges, in order, as key bytes 0 to 6. `key_byte` has no effect on the keystream after the seventh capture.
- R3: Key scheduling first sets S[n]=n for n=0..255. It then performs 256 steps j=(j+S[n]+key[n mod 7]) mod 256, each swapping S[n] and S[j], with j starting at 0.
- R4: The first 1536 generator bytes are discarded. The first byte presented, when `ready` rises, is generator byte number 1537.
- R5: `ready` rises exactly 1801 rising edges after `rst` falls: 7 capture, 1 initialisation, 256 scheduling and 1537 generator steps. Once high, `ready` stays high until reset.
- R6: While `ready` is high, each rising edge with `next_req` high replaces `ks_byte` with the next keystream byte. An edge with `next_req` low leaves `ks_byte` unchanged.
- R7: `next_req` has no effect while `ready` is low. Neither the time at which `ready` rises nor the bytes produced are changed by it.
- R8: Raising `rst` during any phase, including output, clears `ready` at the next edge. A fresh key loaded afterwards produces its own correct stream.
- R9: Each generator step computes i=i+1, then j=j+S[i], swaps S[i] and S[j], and outputs S[(S[i]+S[j]) mod 256], all modulo 256, with i and j starting at 0 after key scheduling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| key_byte | input | 8 | Serial key byte, one per clock during capture |
| next_req | input | 1 | Request for the next keystream byte while ready |
| ready | output | 1 | Keystream byte on ks_byte is valid |
| ks_byte | output | 8 | Current keystream byte |

## Verification
The bench drives inputs and samples outputs on falling edges. `ready` is due on the 1801st rising edge after `rst` falls, so the bench counts falling edges from reset release and expects the first high reading after exactly 1801 of them. A requested keystream byte appears on the rising edge that samples `next_req`, so it is compared at the following falling edge. Idle cycles between requests are checked for an unchanged byte. Expected bytes come from a behavioural model of the key schedule and generator in the bench.

// File: rtl/rc4_stream_gen.sv
module rc4_stream_gen #(
  parameter int KEY_LEN = 7,
  parameter int DISCARD = 1536
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] key_byte,
  input  logic       next_req,
  output logic       ready,
  output logic [7:0] ks_byte
);
  localparam int KW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam int CW = $clog2(DISCARD + 1);

  typedef enum logic [2:0] {S_LOAD, S_INIT, S_KSA, S_DROP, S_RUN} phase_t;

  phase_t        phase;
  logic [7:0]    sbox    [256];
  logic [7:0]    key_mem [KEY_LEN];
  logic [KW-1:0] kpos;
  logic [7:0]    i_q, j_q;
  logic [CW-1:0] drop_cnt;

  logic [7:0] ksa_j, gen_i, gen_j, s_i, s_j, t_idx, gen_out;
  logic [7:0] swap_a, swap_b;
  logic       swap_en, gen_step;

  assign ksa_j   = j_q + sbox[i_q] + key_mem[kpos];
  assign gen_i   = i_q + 8'd1;
  assign gen_j   = j_q + sbox[gen_i];
  assign s_i     = sbox[gen_i];
  assign s_j     = sbox[gen_j];
  assign t_idx   = s_i + s_j;
  assign gen_out = (t_idx == gen_i) ? s_j : (t_idx == gen_j) ? s_i : sbox[t_idx];

  assign gen_step = (phase == S_DROP) || (phase == S_RUN && next_req);
  assign swap_en  = (phase == S_KSA) || gen_step;
  assign swap_a   = (phase == S_KSA) ? i_q   : gen_i;
  assign swap_b   = (phase == S_KSA) ? ksa_j : gen_j;
  assign ready    = (phase == S_RUN);

  always_ff @(posedge clk) begin
    if (!rst && phase == S_INIT) begin
      for (int n = 0; n < 256; n++) sbox[n] <= 8'(n);
    end else if (!rst && swap_en) begin
      sbox[swap_a] <= sbox[swap_b];
      sbox[swap_b] <= sbox[swap_a];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && phase == S_LOAD) key_mem[kpos] <= key_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= S_LOAD;
      kpos     <= '0;
      i_q      <= '0;
      j_q      <= '0;
      drop_cnt <= '0;
      ks_byte  <= '0;
    end else begin
      case (phase)
        S_LOAD: begin
          if (kpos == KW'(KEY_LEN - 1)) begin
            kpos  <= '0;
            phase <= S_INIT;
          end else begin
            kpos <= kpos + 1'b1;
          end
        end
        S_INIT: phase <= S_KSA;
        S_KSA: begin
          j_q  <= ksa_j;
          i_q  <= i_q + 8'd1;
          kpos <= (kpos == KW'(KEY_LEN - 1)) ? '0 : kpos + 1'b1;
          if (i_q == 8'd255) begin
            i_q   <= '0;
            j_q   <= '0;
            phase <= S_DROP;
          end
        end
        S_DROP: begin
          i_q     <= gen_i;
          j_q     <= gen_j;
          ks_byte <= gen_out;
          if (drop_cnt == CW'(DISCARD)) phase <= S_RUN;
          else drop_cnt <= drop_cnt + 1'b1;
        end
        S_RUN: begin
          if (next_req) begin
            i_q     <= gen_i;
            j_q     <= gen_j;
            ks_byte <= gen_out;
          end
        end
        default: phase <= S_LOAD;
      endcase
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!ready && phase == S_LOAD && i_q == 8'd0 && j_q == 8'd0));

  a_r2_load_len: assert property (@(posedge clk) disable iff (rst)
    (phase == S_LOAD && kpos == KW'(KEY_LEN - 1)) |=> (phase == S_INIT));

  a_r4_discard_done: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(drop_cnt) == CW'(DISCARD)));

  a_r5_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (ready && !next_req) |=> $stable(ks_byte));
endmodule

// File: tb/test_rc4_stream_gen.sv
module test_rc4_stream_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DROP_N     = 1536;
  localparam int READY_AT   = 1801;
  localparam int NB         = 24;
  localparam int NV         = 3;
  localparam logic [7:0] KEYS [NV][7] = '{
    '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07},
    '{8'hFF, 8'h00, 8'h80, 8'h7F, 8'hC3, 8'h3C, 8'h5A},
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}
  };
  localparam int GAPS  [NV] = '{0, 1, 3};
  localparam bit NOISY [NV] = '{1'b0, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] key_byte = 8'h00;
  logic next_req = 1'b0;
  logic ready;
  logic [7:0] ks_byte;

  int pass_cnt = 0;
  int fail_cnt = 0;
  int exp_q [NB];

  always #(CLK_PERIOD / 2) clk = ~clk;

  rc4_stream_gen i_rc4_stream_gen (
    .clk(clk), .rst(rst), .key_byte(key_byte), .next_req(next_req),
    .ready(ready), .ks_byte(ks_byte)
  );

  task automatic chk(input string req, input int act, input int exp);
    if (act == exp) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
  endtask

  task automatic build_ref(input int v);
    int s [256];
    int i, j, t, tmp;
    for (int n = 0; n < 256; n++) s[n] = n;
    j = 0;
    for (int n = 0; n < 256; n++) begin
      j = (j + s[n] + int'(KEYS[v][n % 7])) % 256;
      tmp = s[n]; s[n] = s[j]; s[j] = tmp;
    end
    i = 0; j = 0;
    for (int n = 0; n < DROP_N + NB; n++) begin
      i = (i + 1) % 256;
      j = (j + s[i]) % 256;
      tmp = s[i]; s[i] = s[j]; s[j] = tmp;
      t = (s[i] + s[j]) % 256;
      if (n >= DROP_N) exp_q[n - DROP_N] = s[t];
    end
  endtask

  // Reset, then serial key load; R2, R5, R7: counts edges to ready
  task automatic start_key(input int v, input bit noisy);
    int cnt;
    @(negedge clk);
    rst = 1'b1;
    next_req = noisy;
    @(negedge clk);
    @(negedge clk);
    chk("R1 ready low in reset", int'(ready), 0);
    rst = 1'b0;
    key_byte = KEYS[v][0];
    cnt = 0;
    while (!ready && cnt < 3000) begin
      @(negedge clk);
      cnt++;
      if (cnt < 7) key_byte = KEYS[v][cnt];
      else key_byte = noisy ? 8'(cnt * 37 + 11) : 8'h00;
    end
    next_req = 1'b0;
    chk("R5 edges until ready", cnt, READY_AT);
  endtask

  task automatic check_stream(input int v, input int gap);
    build_ref(v);
    chk("R4 first byte after discard", int'(ks_byte), exp_q[0]);
    for (int n = 1; n < NB; n++) begin
      next_req = 1'b1;
      @(negedge clk);
      if (gap > 0) next_req = 1'b0;
      chk("R9 R6 keystream byte", int'(ks_byte), exp_q[n]);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk("R6 idle hold", int'(ks_byte), exp_q[n]);
      end
    end
    next_req = 1'b0;
    chk("R5 ready stays high", int'(ready), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fail_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // Vector table walk: R2 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      start_key(v, NOISY[v]);
      check_stream(v, GAPS[v]);
    end

    // R8: reset during output clears ready at next edge
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R8 ready cleared after reset", int'(ready), 0);
    chk("R1 output byte zero in reset", int'(ks_byte), 0);
    start_key(1, 1'b0);
    check_stream(1, 0);

    // R8: reset during key scheduling, then reload
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    key_byte = KEYS[2][0];
    for (int c = 1; c < 100; c++) begin
      @(negedge clk);
      if (c < 7) key_byte = KEYS[2][c];
    end
    chk("R8 not ready mid-schedule", int'(ready), 0);
    start_key(0, 1'b1);
    check_stream(0, 2);

    summary();
    $finish;
  end
endmodule